// File: doc/BRIEF.md
# Packed Lane Add, Subtract and Average Unit

This block is a SIMD integer datapath for a 64-bit execution pipe. Both 64-bit operands are split into equal lanes of 8, 16 or 32 bits. Every lane is processed on its own, and no carry, borrow or rounding bit crosses into the next lane. One operation code selects one of these families:

- add or subtract that wraps around;
- add or subtract that clamps to the signed range of the lane;
- add or subtract that clamps to the unsigned range of the lane, with the second operand read as either unsigned or signed;
- halving average of the two lanes, with or without rounding;
- halving of the lane difference.

The lane arithmetic is combinational. By default an output register adds one cycle of latency. When the operation code and the lane size do not form a legal pair, the block returns an all-zero word and raises a flag, so that the pipe can raise its own fault.

Top module: `packedAddAvg`

## Requirements
- R1: With opSel 0 (add) or 4 (subtract), each lane of `result` is the low lane-width bits of opA ± opB. elemSize 0, 1 and 2 select 8-, 16- and 32-bit lanes, and no carry or borrow moves between lanes.
- R2: With opSel 1 (add) or 5 (subtract), both lanes are read as two's complement. The true result is clamped to the range from -2^(W-1) to 2^(W-1)-1, where W is the lane width.
- R3: With opSel 2 (add) or 6 (subtract), both lanes are read as unsigned. The true result is clamped to the range from 0 to 2^W-1.
- R4: With opSel 3 (add) or 7 (subtract), the opA lane is read as unsigned and the opB lane as two's complement. The true result is clamped to the range from 0 to 2^W-1.
- R5: With opSel 8, each lane is (a+b)>>1 over both lanes read as unsigned. The carry out of the lane sum becomes bit W-1 of the result.
- R6: With opSel 9, each lane is (a+b+1)>>1 over both lanes read as unsigned, which rounds halves away from zero.
- R7: With opSel 10, each lane is bits W down to 1 of the (W+1)-bit two's-complement difference a-b, where both lanes are zero-extended. This equals floor((a-b)/2).
- R8: The following requests give `result` = 0 with `illegalOp` = 1: elemSize 3; opSel 11 to 15; elemSize 2 with any opSel other than 0 or 4. Every other request gives `illegalOp` = 0.
- R9: With REG_OUT = 1, `result` and `illegalOp` show the request sampled at the previous rising clock edge. While rstN is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low synchronous reset |
| opA | input | 64 | First packed operand |
| opB | input | 64 | Second packed operand |
| elemSize | input | 2 | Lane size: 0 = 8, 1 = 16, 2 = 32 bits, 3 = reserved |
| opSel | input | 4 | Operation code (see R1 to R8) |
| result | output | 64 | Packed lane results |
| illegalOp | output | 1 | Unsupported size and operation pair |

## Verification
Four properties are checked on every cycle of the low 8-bit lane:

- signed clamping never flips the sign when both inputs are non-negative;
- unsigned-clamped add never falls below opA;
- unsigned-clamped subtract never rises above opA;
- the plain average stays between the two inputs.

In addition, the flagged requests always read as zero, and a reserved size is always flagged on the following cycle.

Only the bench's scenarios can show the exact lane values and the isolation of lanes across sizes. The extreme inputs at each width also come only from the bench: zero, all ones, the signed maximum and the signed minimum. The same holds for the rounding difference between R5 and R6 and for the one-cycle latency.

// File: rtl/pasPkg.sv
package pasPkg;
  localparam int DW = 64;
  localparam int NSIZE = 3;

  typedef enum logic [3:0] {
    OP_ADD      = 4'd0,
    OP_ADD_SS   = 4'd1,
    OP_ADD_UU   = 4'd2,
    OP_ADD_US   = 4'd3,
    OP_SUB      = 4'd4,
    OP_SUB_SS   = 4'd5,
    OP_SUB_UU   = 4'd6,
    OP_SUB_US   = 4'd7,
    OP_AVG      = 4'd8,
    OP_AVG_RND  = 4'd9,
    OP_AVG_DIFF = 4'd10
  } pasOpE;

  typedef enum logic [1:0] {
    SZ_B8   = 2'd0,
    SZ_B16  = 2'd1,
    SZ_B32  = 2'd2,
    SZ_RSVD = 2'd3
  } pasSizeE;

  typedef enum logic [1:0] {
    RES_WRAP = 2'd0,
    RES_SSAT = 2'd1,
    RES_USAT = 2'd2,
    RES_AVG  = 2'd3
  } pasResE;

  typedef struct packed {
    logic       doSub;
    logic       aSigned;
    logic       bSigned;
    logic       roundUp;
    pasResE     resMode;
    logic [1:0] sizeSel;
    logic       illegal;
  } pasCtrlT;
endpackage

// File: rtl/pasLane.sv
module pasLane
  import pasPkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] laneA,
  input  logic [W-1:0] laneB,
  input  pasCtrlT      ctrl,
  output logic [W-1:0] laneY
);
  localparam int XW = W + 2;

  logic [XW-1:0] extA;
  logic [XW-1:0] extB;
  logic [XW-1:0] rawSum;
  logic          ovfSigned;

  always_comb begin
    extA = {{2{ctrl.aSigned & laneA[W-1]}}, laneA};
    extB = {{2{ctrl.bSigned & laneB[W-1]}}, laneB};
    if (ctrl.doSub) rawSum = extA - extB;
    else            rawSum = extA + extB + XW'(ctrl.roundUp);
    ovfSigned = (rawSum[W+1:W-1] != 3'b000) && (rawSum[W+1:W-1] != 3'b111);
    case (ctrl.resMode)
      RES_SSAT: begin
        if (!ovfSigned)       laneY = rawSum[W-1:0];
        else if (rawSum[W+1]) laneY = {1'b1, {(W-1){1'b0}}};
        else                  laneY = {1'b0, {(W-1){1'b1}}};
      end
      RES_USAT: begin
        if (rawSum[W+1])      laneY = '0;
        else if (rawSum[W])   laneY = '1;
        else                  laneY = rawSum[W-1:0];
      end
      RES_AVG:  laneY = rawSum[W:1];
      default:  laneY = rawSum[W-1:0];
    endcase
  end
endmodule

// File: rtl/pasControl.sv
module pasControl
  import pasPkg::*;
(
  input  logic [3:0] opSel,
  input  logic [1:0] elemSize,
  output pasCtrlT    ctrl
);
  logic opKnown;
  logic wrapOnly;

  always_comb begin
    ctrl         = '0;
    ctrl.sizeSel = elemSize;
    opKnown      = 1'b1;
    wrapOnly     = 1'b0;
    case (opSel)
      OP_ADD:      wrapOnly = 1'b1;
      OP_SUB:      begin wrapOnly = 1'b1; ctrl.doSub = 1'b1; end
      OP_ADD_SS:   begin ctrl.resMode = RES_SSAT; ctrl.aSigned = 1'b1; ctrl.bSigned = 1'b1; end
      OP_SUB_SS:   begin ctrl.resMode = RES_SSAT; ctrl.aSigned = 1'b1; ctrl.bSigned = 1'b1;
                         ctrl.doSub = 1'b1; end
      OP_ADD_UU:   ctrl.resMode = RES_USAT;
      OP_SUB_UU:   begin ctrl.resMode = RES_USAT; ctrl.doSub = 1'b1; end
      OP_ADD_US:   begin ctrl.resMode = RES_USAT; ctrl.bSigned = 1'b1; end
      OP_SUB_US:   begin ctrl.resMode = RES_USAT; ctrl.bSigned = 1'b1; ctrl.doSub = 1'b1; end
      OP_AVG:      ctrl.resMode = RES_AVG;
      OP_AVG_RND:  begin ctrl.resMode = RES_AVG; ctrl.roundUp = 1'b1; end
      OP_AVG_DIFF: begin ctrl.resMode = RES_AVG; ctrl.doSub = 1'b1; end
      default:     opKnown = 1'b0;
    endcase
    case (elemSize)
      SZ_B8, SZ_B16: ctrl.illegal = !opKnown;
      SZ_B32:        ctrl.illegal = !wrapOnly;
      default:       ctrl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/pasDatapath.sv
module pasDatapath
  import pasPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  input  pasCtrlT       ctrl,
  output logic [DW-1:0] dataOut
);
  logic [DW-1:0] sizeRes [NSIZE];

  for (genvar gs = 0; gs < NSIZE; gs++) begin : gSize
    localparam int W  = 8 << gs;
    localparam int NL = DW / W;
    logic [DW-1:0] laneBus;
    for (genvar gl = 0; gl < NL; gl++) begin : gLane
      pasLane #(.W(W)) uLane (
        .laneA (opA[gl*W +: W]),
        .laneB (opB[gl*W +: W]),
        .ctrl  (ctrl),
        .laneY (laneBus[gl*W +: W])
      );
    end
    assign sizeRes[gs] = laneBus;
  end

  always_comb begin
    if (ctrl.illegal) dataOut = '0;
    else begin
      case (ctrl.sizeSel)
        SZ_B8:   dataOut = sizeRes[0];
        SZ_B16:  dataOut = sizeRes[1];
        SZ_B32:  dataOut = sizeRes[2];
        default: dataOut = '0;
      endcase
    end
  end

  logic sel8;
  assign sel8 = !ctrl.illegal && (ctrl.sizeSel == SZ_B8);

  AST_SSAT_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (sel8 && ctrl.resMode == RES_SSAT && !ctrl.doSub && !opA[7] && !opB[7]) |-> !dataOut[7]); // R2
  AST_USAT_ADD_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (sel8 && ctrl.resMode == RES_USAT && !ctrl.doSub && !ctrl.bSigned) |-> (dataOut[7:0] >= opA[7:0])); // R3
  AST_USAT_SUB_CEIL: assert property (@(posedge clk) disable iff (!rstN)
    (sel8 && ctrl.resMode == RES_USAT && ctrl.doSub && !ctrl.bSigned) |-> (dataOut[7:0] <= opA[7:0])); // R3
  AST_AVG_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    (sel8 && ctrl.resMode == RES_AVG && !ctrl.doSub && !ctrl.roundUp) |->
      ((dataOut[7:0] >= ((opA[7:0] < opB[7:0]) ? opA[7:0] : opB[7:0])) &&
       (dataOut[7:0] <= ((opA[7:0] < opB[7:0]) ? opB[7:0] : opA[7:0])))); // R5
endmodule

// File: rtl/packedAddAvg.sv
module packedAddAvg
  import pasPkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  input  logic [1:0]    elemSize,
  input  logic [3:0]    opSel,
  output logic [DW-1:0] result,
  output logic          illegalOp
);
  pasCtrlT       ctrl;
  logic [DW-1:0] dataOut;

  pasControl uControl (
    .opSel    (opSel),
    .elemSize (elemSize),
    .ctrl     (ctrl)
  );

  pasDatapath uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .opA     (opA),
    .opB     (opB),
    .ctrl    (ctrl),
    .dataOut (dataOut)
  );

  if (REG_OUT) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        result    <= '0;
        illegalOp <= 1'b0;
      end else begin
        result    <= dataOut;
        illegalOp <= ctrl.illegal;
      end
    end

    AST_RSVD_SIZE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      (elemSize == SZ_RSVD) |=> illegalOp); // R8
  end else begin : gComb
    assign result    = dataOut;
    assign illegalOp = ctrl.illegal;
  end

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (result == '0)); // R8
endmodule

// File: tb/tb_packedAddAvg.sv
module tb_packedAddAvg;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rstN;
  logic [63:0] opA;
  logic [63:0] opB;
  logic [1:0]  elemSize;
  logic [3:0]  opSel;
  logic [63:0] result;
  logic        illegalOp;

  int errors = 0;
  int checks = 0;

  packedAddAvg dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB),
    .elemSize(elemSize), .opSel(opSel), .result(result), .illegalOp(illegalOp)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic [1:0]  sz;
    logic [3:0]  op;
  } vecT;

  localparam int NVEC = 14;
  localparam vecT VEC [NVEC] = '{
    '{64'h00FF_7F80_0102_FE01, 64'h0001_0101_FF02_0203, 2'd0, 4'd0},
    '{64'h00FF_7F80_0102_FE01, 64'h0001_0101_FF02_0203, 2'd0, 4'd4},
    '{64'hFFFF_0001_8000_7FFF, 64'h0001_FFFF_8000_0001, 2'd1, 4'd0},
    '{64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0001, 2'd2, 4'd0},
    '{64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 2'd2, 4'd4},
    '{64'h7F80_4040_C0C0_7F01, 64'h0101_4040_C0C1_8101, 2'd0, 4'd1},
    '{64'h7FFF_8000_1234_8001, 64'hFFFF_0001_4000_0002, 2'd1, 4'd5},
    '{64'hF0F0_1010_FF00_8080, 64'h2020_2020_0201_8080, 2'd0, 4'd2},
    '{64'h0010_FFF0_8000_0001, 64'h0020_0001_8001_0000, 2'd1, 4'd6},
    '{64'h00FF_8010_7F05_F0F0, 64'h7FFF_8090_8120_1080, 2'd0, 4'd3},
    '{64'h0005_FFF0_8000_0100, 64'h8000_7FFF_FFFF_0101, 2'd1, 4'd7},
    '{64'hFF01_0302_FFFE_8081, 64'hFF02_0403_0001_7F80, 2'd0, 4'd8},
    '{64'hFFFF_0003_0001_8001, 64'hFFFF_0004_0000_7FFF, 2'd1, 4'd9},
    '{64'h00FF_0103_FF00_8001, 64'hFF00_0302_00FF_0180, 2'd0, 4'd10}
  };

  function automatic void refModel(input logic [63:0] a, input logic [63:0] b,
                                   input logic [1:0] sz, input logic [3:0] op,
                                   output logic [63:0] y, output logic ill);
    int w;
    longint one, ua, ub, sa, sb, r, hiS, loS, hiU;
    logic [63:0] mask;
    one = 1;
    w   = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    ill = (sz == 2'd3) || (op > 4'd10) || (sz == 2'd2 && !(op == 4'd0 || op == 4'd4));
    y   = '0;
    if (ill) return;
    mask = (64'd1 << w) - 64'd1;
    hiS  = (one <<< (w-1)) - 1;
    loS  = -(one <<< (w-1));
    hiU  = (one <<< w) - 1;
    for (int i = 0; i < 64 / w; i++) begin
      ua = longint'((a >> (i*w)) & mask);
      ub = longint'((b >> (i*w)) & mask);
      sa = (ua > hiS) ? ua - (one <<< w) : ua;
      sb = (ub > hiS) ? ub - (one <<< w) : ub;
      case (op)
        4'd0: r = ua + ub;
        4'd4: r = ua - ub;
        4'd1: r = sa + sb;
        4'd5: r = sa - sb;
        4'd2: r = ua + ub;
        4'd6: r = ua - ub;
        4'd3: r = ua + sb;
        4'd7: r = ua - sb;
        4'd8: r = (ua + ub) >>> 1;
        4'd9: r = (ua + ub + 1) >>> 1;
        default: r = (ua - ub) >>> 1;
      endcase
      if (op == 4'd1 || op == 4'd5) r = (r > hiS) ? hiS : (r < loS) ? loS : r;
      if (op == 4'd2 || op == 4'd3 || op == 4'd6 || op == 4'd7) r = (r > hiU) ? hiU : (r < 0) ? 0 : r;
      y |= (64'(r) & mask) << (i*w);
    end
  endfunction

  function automatic string reqOf(input logic [1:0] sz, input logic [3:0] op);
    if (sz == 2'd3 || op > 4'd10 || (sz == 2'd2 && !(op == 4'd0 || op == 4'd4))) return "R8";
    case (op)
      4'd0, 4'd4: return "R1";
      4'd1, 4'd5: return "R2";
      4'd2, 4'd6: return "R3";
      4'd3, 4'd7: return "R4";
      4'd8:       return "R5";
      4'd9:       return "R6";
      default:    return "R7";
    endcase
  endfunction

  task automatic checkOut(input string req, input logic [63:0] expY, input logic expIll);
    checks++;
    if (result !== expY || illegalOp !== expIll) begin
      errors++;
      $display("FAIL %s: result=%h ill=%b expected result=%h ill=%b", req, result, illegalOp, expY, expIll);
    end
  endtask

  task automatic runVec(input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] sz, input logic [3:0] op);
    logic [63:0] expY;
    logic        expIll;
    @(negedge clk);
    opA = a; opB = b; elemSize = sz; opSel = op;
    refModel(a, b, sz, op, expY, expIll);
    @(negedge clk);
    checkOut(reqOf(sz, op), expY, expIll);
  endtask

  function automatic logic [63:0] pattern(input logic [1:0] sz, input int kind);
    int w;
    logic [63:0] lane, y;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    case (kind)
      0:       lane = 64'd0;
      1:       lane = (64'd1 << w) - 64'd1;
      2:       lane = (64'd1 << (w-1)) - 64'd1;
      default: lane = 64'd1 << (w-1);
    endcase
    y = '0;
    for (int i = 0; i < 64 / w; i++) y |= lane << (i*w);
    return y;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog R9: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] expY;
    logic        expIll;
    rstN = 1'b0; opA = '0; opB = '0; elemSize = 2'd3; opSel = 4'd15;
    repeat (3) @(negedge clk);
    checkOut("R9", 64'd0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) runVec(VEC[i].a, VEC[i].b, VEC[i].sz, VEC[i].op);

    for (int sz = 0; sz < 3; sz++)
      for (int op = 0; op < 11; op++)
        for (int ka = 0; ka < 4; ka++)
          for (int kb = 0; kb < 4; kb++)
            runVec(pattern(2'(sz), ka), pattern(2'(sz), kb), 2'(sz), 4'(op));

    for (int op = 11; op < 16; op++) runVec(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'd0, 4'(op));
    for (int op = 0; op < 16; op++) runVec(64'h0123_4567_89AB_CDEF, 64'h1111, 2'd3, 4'(op));
    for (int op = 0; op < 11; op++) runVec(64'h8000_0000_7FFF_FFFF, 64'h8000_0000_0000_0001, 2'd2, 4'(op));

    runVec(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 2'd0, 4'd0);
    @(negedge clk);
    opA = 64'h5; opB = 64'h3; elemSize = 2'd1; opSel = 4'd4;
    #1;
    checkOut("R9", 64'h0, 1'b0);
    refModel(64'h5, 64'h3, 2'd1, 4'd4, expY, expIll);
    @(negedge clk);
    checkOut("R9", expY, expIll);

    runVec(64'h0000_0000_0000_00FF, 64'h0, 2'd0, 4'd0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkOut("R9", 64'd0, 1'b0);
    rstN = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule